// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a synchronous true dual-port memory with two identical ports, left and right. Each port can read or write any word on every clock edge. The two highest words of the address space also serve as a doorbell pair between the ports. A port that writes the doorbell word owned by its partner raises that partner's active-low interrupt. The partner drops the interrupt again by reading the same word. The doorbell words still hold data like any other location, so the writer can leave a message there for the reader.

Collision arbitration is not built in. Each port gets an active-low busy input from outside. While a port's busy input is asserted, the accesses it makes cannot change any interrupt flag. Its memory traffic goes ahead as usual. All accesses are sampled on the rising clock edge. Read data and flag changes appear one cycle later. The address width is a parameter: the full-size part uses 16 bits, and the default is smaller so that elaboration stays light.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: A port writes wdata to addr when ce_n=0 and we_n=0 at a clock edge. It reads when ce_n=0, we_n=1 and oe_n=0, and rdata shows the stored word one cycle later. At all other times rdata holds its last value.
- R2: If both ports write the same address in the same cycle, the left port's data is stored.
- R3: A left write to the all-ones address while l_busy_n=1 drives r_int_n low in the next cycle.
- R4: A right read of the all-ones address while r_busy_n=1 returns r_int_n high in the next cycle.
- R5: A right write to the all-ones-minus-one address while r_busy_n=1 drives l_int_n low in the next cycle.
- R6: A left read of the all-ones-minus-one address while l_busy_n=1 returns l_int_n high in the next cycle.
- R7: A set or clear action made by a port whose busy_n is 0 leaves the flag unchanged.
- R8: If a set and a clear of the same flag occur in the same cycle, the flag goes low (set wins).
- R9: After reset, both int_n outputs are 1 and both rdata outputs are 0.
- R10: The two doorbell addresses store and return data like ordinary locations.
- R11: A read on one port of an address that the other port writes in the same cycle returns the previous contents.
- R12: The following do not change either flag: a port writing its own doorbell word (left to all-ones-minus-one, right to all-ones); an access with oe_n=1 and we_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy, active low, blocks flag actions |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, one-cycle latency |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy, active low, blocks flag actions |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, one-cycle latency |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The bench targets four corner cases:

- A doorbell write and the partner's clearing read in the same cycle. A design that let the clear win would leave the interrupt high, and the message would be lost.
- Busy asserted on only the acting port. A design that checked the wrong port's busy would set or clear a flag it should not touch.
- A port writing its own doorbell word. A design with the mailbox addresses swapped would raise the port's own interrupt.
- Simultaneous writes to one address, and a read racing a write on the other port. A design with the wrong write priority, or that read after write, would return the wrong word.

Random traffic is weighted toward the top addresses and a few low ones, so these cases also come up mixed with each other.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef enum logic {
    PORT_LEFT  = 1'b0,
    PORT_RIGHT = 1'b1
  } port_e;

  // A write needs chip enable and write enable, both active low.
  function automatic logic access_is_write(input logic ce_n, input logic we_n);
    return !ce_n && !we_n;
  endfunction

  // A read needs chip enable and output enable with write enable idle.
  function automatic logic access_is_read(input logic ce_n, input logic we_n,
                                          input logic oe_n);
    return !ce_n && we_n && !oe_n;
  endfunction

  // Next value of an active-low flag; set has priority over clear.
  function automatic logic flag_next_n(input logic cur_n, input logic set,
                                       input logic clr);
    if (set) return 1'b0;
    if (clr) return 1'b1;
    return cur_n;
  endfunction

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
#(
  parameter int           AW        = 10,
  parameter logic [AW-1:0] OWN_BOX  = '1,
  parameter logic [AW-1:0] PEER_BOX = '1
) (
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          busy_n,
  input  logic [AW-1:0] addr,
  output logic          wr_ev,
  output logic          rd_ev,
  output logic          ring_peer,
  output logic          ack_own
);

  always_comb begin
    wr_ev     = access_is_write(ce_n, we_n);
    rd_ev     = access_is_read(ce_n, we_n, oe_n);
    // ringing the partner: write to the partner's doorbell word
    ring_peer = wr_ev && busy_n && (addr == PEER_BOX);
    // acknowledging: read of this port's own doorbell word
    ack_own   = rd_ev && busy_n && (addr == OWN_BOX);
  end

endmodule

// File: rtl/dpm_storage.sv
module dpm_storage #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_l,
  input  logic          rd_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] din_l,
  output logic [DW-1:0] dout_l,
  input  logic          wr_r,
  input  logic          rd_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] din_r,
  output logic [DW-1:0] dout_r
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Right is written first so that a left write to the same word lands last.
  always_ff @(posedge clk) begin
    if (wr_r) mem[addr_r] <= din_r;
    if (wr_l) mem[addr_l] <= din_l;
  end

  // Reads see the contents from before this edge's writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_l <= '0;
      dout_r <= '0;
    end else begin
      if (rd_l) dout_l <= mem[addr_l];
      if (rd_r) dout_r <= mem[addr_r];
    end
  end

  // Shadow of the previous cycle's writes, kept only for the checks below.
  logic          sh_wl, sh_wr, sh_both;
  logic [AW-1:0] sh_al, sh_ar;
  logic [DW-1:0] sh_dl, sh_dr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_wl <= 1'b0; sh_wr <= 1'b0; sh_both <= 1'b0;
      sh_al <= '0;   sh_ar <= '0;   sh_dl <= '0; sh_dr <= '0;
    end else begin
      sh_wl   <= wr_l;
      sh_wr   <= wr_r;
      sh_both <= wr_l && wr_r && (addr_l == addr_r);
      sh_al   <= addr_l;
      sh_ar   <= addr_r;
      sh_dl   <= din_l;
      sh_dr   <= din_r;
    end
  end

  assert_wr_then_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wl && rd_l && addr_l == sh_al && !(wr_r && addr_r == addr_l))
      |=> dout_l == $past(sh_dl));

  assert_left_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_both && rd_r && addr_r == sh_al && !(wr_l && addr_l == addr_r))
      |=> dout_r == $past(sh_dl));

  assert_rd_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && !sh_both && rd_l && addr_l == sh_ar && wr_r && addr_r == addr_l)
      |=> dout_l == $past(sh_dr));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_l |=> $stable(dout_l));

endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag
  import dpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_n <= 1'b1;
    else        flag_n <= flag_next_n(flag_n, set, clr);
  end

  assert_set_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !flag_n);

  assert_clear_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> flag_n);

  assert_quiet_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag_n));

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic          l_busy_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_int_n,
  input  logic          r_ce_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic          r_busy_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_int_n
);

  localparam int            NPORT   = 2;
  localparam logic [AW-1:0] BOX_TOP = '1;             // right port's doorbell
  localparam logic [AW-1:0] BOX_LOW = BOX_TOP - 1'b1; // left port's doorbell

  logic          p_ce_n   [NPORT];
  logic          p_we_n   [NPORT];
  logic          p_oe_n   [NPORT];
  logic          p_busy_n [NPORT];
  logic [AW-1:0] p_addr   [NPORT];
  logic          p_wr     [NPORT];
  logic          p_rd     [NPORT];
  logic          p_ring   [NPORT];
  logic          p_ack    [NPORT];
  logic          p_flag_n [NPORT];

  always_comb begin
    p_ce_n[PORT_LEFT]    = l_ce_n;   p_ce_n[PORT_RIGHT]   = r_ce_n;
    p_we_n[PORT_LEFT]    = l_we_n;   p_we_n[PORT_RIGHT]   = r_we_n;
    p_oe_n[PORT_LEFT]    = l_oe_n;   p_oe_n[PORT_RIGHT]   = r_oe_n;
    p_busy_n[PORT_LEFT]  = l_busy_n; p_busy_n[PORT_RIGHT] = r_busy_n;
    p_addr[PORT_LEFT]    = l_addr;   p_addr[PORT_RIGHT]   = r_addr;
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam logic [AW-1:0] OWN  = (g == 0) ? BOX_LOW : BOX_TOP;
    localparam logic [AW-1:0] PEER = (g == 0) ? BOX_TOP : BOX_LOW;

    dpm_port_decode #(.AW(AW), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .ce_n      (p_ce_n[g]),
      .we_n      (p_we_n[g]),
      .oe_n      (p_oe_n[g]),
      .busy_n    (p_busy_n[g]),
      .addr      (p_addr[g]),
      .wr_ev     (p_wr[g]),
      .rd_ev     (p_rd[g]),
      .ring_peer (p_ring[g]),
      .ack_own   (p_ack[g])
    );

    // this port's flag is set by the partner's ring and cleared by its own ack
    dpm_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (p_ring[NPORT-1-g]),
      .clr    (p_ack[g]),
      .flag_n (p_flag_n[g])
    );
  end

  dpm_storage #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_l   (p_wr[PORT_LEFT]),
    .rd_l   (p_rd[PORT_LEFT]),
    .addr_l (l_addr),
    .din_l  (l_wdata),
    .dout_l (l_rdata),
    .wr_r   (p_wr[PORT_RIGHT]),
    .rd_r   (p_rd[PORT_RIGHT]),
    .addr_r (r_addr),
    .din_r  (r_wdata),
    .dout_r (r_rdata)
  );

  assign l_int_n = p_flag_n[PORT_LEFT];
  assign r_int_n = p_flag_n[PORT_RIGHT];

  // Port-level checks on the flag rules.
  assert_ring_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_we_n && l_busy_n && l_addr == BOX_TOP) |=> !r_int_n);

  assert_ring_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_we_n && r_busy_n && r_addr == BOX_LOW) |=> !l_int_n);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && !(!l_ce_n && !l_we_n && l_busy_n && l_addr == BOX_TOP))
      |=> $stable(r_int_n));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_we_n && l_busy_n && l_addr == BOX_TOP &&
     !r_ce_n && r_we_n && !r_oe_n && r_busy_n && r_addr == BOX_TOP) |=> !r_int_n);

endmodule

// File: tb/dpm_mailbox_ram_test.sv
`timescale 1ns/1ps
module dpm_mailbox_ram_test;

  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP = DEPTH - 1;
  localparam logic [AW-1:0] LOW = DEPTH - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n = 1, l_we_n = 1, l_oe_n = 1, l_busy_n = 1;
  logic r_ce_n = 1, r_we_n = 1, r_oe_n = 1, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_int_n, r_int_n;

  always #2.5 clk = ~clk;

  dpm_mailbox_ram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_dl = '0, m_dr = '0;
  logic m_il = 1'b1, m_ir = 1'b1;

  function automatic bit f_wr(logic ce, logic we);
    return (ce == 0) && (we == 0);
  endfunction
  function automatic bit f_rd(logic ce, logic we, logic oe);
    return (ce == 0) && (we == 1) && (oe == 0);
  endfunction
  function automatic logic f_flag(logic cur, bit set, bit clr);
    return set ? 1'b0 : (clr ? 1'b1 : cur);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1;
    r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1;
  endtask

  task automatic drv_l(logic ce, logic we, logic oe, logic busy, logic [AW-1:0] a, logic [DW-1:0] d);
    l_ce_n = ce; l_we_n = we; l_oe_n = oe; l_busy_n = busy; l_addr = a; l_wdata = d;
  endtask
  task automatic drv_r(logic ce, logic we, logic oe, logic busy, logic [AW-1:0] a, logic [DW-1:0] d);
    r_ce_n = ce; r_we_n = we; r_oe_n = oe; r_busy_n = busy; r_addr = a; r_wdata = d;
  endtask

  // one clock: update the reference model from the driven inputs, compare at negedge
  task automatic step();
    bit lw, lr, rw, rr;
    @(posedge clk);
    #1;
    lw = f_wr(l_ce_n, l_we_n); lr = f_rd(l_ce_n, l_we_n, l_oe_n);
    rw = f_wr(r_ce_n, r_we_n); rr = f_rd(r_ce_n, r_we_n, r_oe_n);
    m_ir = f_flag(m_ir, lw && l_busy_n && l_addr == TOP, rr && r_busy_n && r_addr == TOP);
    m_il = f_flag(m_il, rw && r_busy_n && r_addr == LOW, lr && l_busy_n && l_addr == LOW);
    if (lr) m_dl = m_mem[l_addr];
    if (rr) m_dr = m_mem[r_addr];
    if (rw) m_mem[r_addr] = r_wdata;
    if (lw) m_mem[l_addr] = l_wdata;
    @(negedge clk);
    chk("R1 R2 R11 model l_rdata", l_rdata, m_dl);
    chk("R1 R2 R11 model r_rdata", r_rdata, m_dr);
    chk("R5 R6 R7 R8 model l_int_n", {15'd0, l_int_n}, {15'd0, m_il});
    chk("R3 R4 R7 R8 model r_int_n", {15'd0, r_int_n}, {15'd0, m_ir});
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int unsigned k = $urandom % 10;
    if (k < 4) return TOP - AW'(k % 3);
    return AW'($urandom % 12);
  endfunction

  initial begin : watchdog
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 l_int_n", {15'd0, l_int_n}, 16'd1);
    chk("R9 r_int_n", {15'd0, r_int_n}, 16'd1);
    chk("R9 l_rdata", l_rdata, 16'h0000);
    chk("R9 r_rdata", r_rdata, 16'h0000);
    rst_n = 1'b1;

    // prefill so all model words are defined; no flag may move (R12)
    for (int i = 0; i < DEPTH - 1; i++) begin
      drv_l(0, 0, 1, 1, AW'(i), DW'(i) ^ 16'h3C5A);
      step();
    end
    idle();
    drv_r(0, 0, 1, 1, TOP, 16'h7E11);
    step();
    idle();
    chk("R12 own box writes leave l_int_n", {15'd0, l_int_n}, 16'd1);
    chk("R12 own box writes leave r_int_n", {15'd0, r_int_n}, 16'd1);

    // R1: write then read back
    drv_l(0, 0, 1, 1, 10'h012, 16'hA5A5); step(); idle();
    drv_l(0, 1, 0, 1, 10'h012, 16'h0); step(); idle();
    chk("R1 read back", l_rdata, 16'hA5A5);
    step();
    chk("R1 rdata held", l_rdata, 16'hA5A5);

    // R3 then R7 then R4
    drv_l(0, 0, 1, 1, TOP, 16'hBEEF); step(); idle();
    chk("R3 r_int_n low", {15'd0, r_int_n}, 16'd0);
    drv_r(0, 1, 0, 0, TOP, 16'h0); step(); idle();
    chk("R7 clear blocked by busy", {15'd0, r_int_n}, 16'd0);
    chk("R10 box data", r_rdata, 16'hBEEF);
    drv_r(0, 1, 1, 1, TOP, 16'h0); step(); idle();
    chk("R12 oe_n high no clear", {15'd0, r_int_n}, 16'd0);
    drv_r(0, 1, 0, 1, TOP, 16'h0); step(); idle();
    chk("R4 r_int_n high", {15'd0, r_int_n}, 16'd1);

    // R7: set blocked by busy
    drv_l(0, 0, 1, 0, TOP, 16'h1111); step(); idle();
    chk("R7 set blocked by busy", {15'd0, r_int_n}, 16'd1);

    // R5, R6, R10
    drv_r(0, 0, 1, 1, LOW, 16'hC0DE); step(); idle();
    chk("R5 l_int_n low", {15'd0, l_int_n}, 16'd0);
    drv_l(0, 1, 0, 1, LOW, 16'h0); step(); idle();
    chk("R6 l_int_n high", {15'd0, l_int_n}, 16'd1);
    chk("R10 box data left", l_rdata, 16'hC0DE);

    // R8: set and clear together
    drv_l(0, 0, 1, 1, TOP, 16'h2222);
    drv_r(0, 1, 0, 1, TOP, 16'h0);
    step(); idle();
    chk("R8 set wins", {15'd0, r_int_n}, 16'd0);
    chk("R11 read old box data", r_rdata, 16'h1111);
    drv_r(0, 1, 0, 1, TOP, 16'h0); step(); idle();
    chk("R4 cleared after R8", {15'd0, r_int_n}, 16'd1);

    // R2: both write same address
    drv_l(0, 0, 1, 1, 10'h005, 16'h1234);
    drv_r(0, 0, 1, 1, 10'h005, 16'h5678);
    step(); idle();
    drv_r(0, 1, 0, 1, 10'h005, 16'h0); step(); idle();
    chk("R2 left data stored", r_rdata, 16'h1234);

    // R11: read racing a write on the other port
    drv_l(0, 0, 1, 1, 10'h007, 16'h9999);
    drv_r(0, 1, 0, 1, 10'h007, 16'h0);
    step(); idle();
    chk("R11 old data", r_rdata, 16'h0007 ^ 16'h3C5A);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      drv_l(($urandom % 5) == 0, ($urandom % 5) >= 2, ($urandom % 5) == 0,
            ($urandom % 7) != 0, pick_addr(), DW'($urandom));
      drv_r(($urandom % 5) == 0, ($urandom % 5) >= 2, ($urandom % 5) == 0,
            ($urandom % 7) != 0, pick_addr(), DW'($urandom));
      step();
    end
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule